// File: doc/BRIEF.md
# Port-Group Egress Mask Resolver

This block turns the forwarding facts known about one frame into the set of egress ports of a small layer-2 switch. It keeps a table of port-group entries, each a bit mask over the physical ports plus one extra bit for the logical CPU port, whose index equals the number of physical ports. For every request it reads three entries of that table. The first is a destination entry, picked by the MAC-table result or, on a miss, by the frame's flood class. The second is an aggregation entry, picked by the 4-bit link aggregation code. The third is a source entry, picked by the ingress port. The resolved mask is the bitwise AND of the three. The one exception is the CPU bit: once the destination entry has set it, neither of the other two entries can remove it.

Table entries are loaded through a simple write port, one entry per cycle. Requests may arrive every cycle. Each request produces exactly one result, with a fixed latency.

The destination part of the table holds entries 0 to 63. Entries below the physical port count are by convention single-port unicast groups. Entry 59 is the CPU copy group. Entries 60 to 63 are the flood groups. Entries 64 to 79 hold aggregation masks and entries 80 upward hold source masks, one per physical port.

Top module: `pgid_resolver`

## Requirements
- R1: While reset is held, and until the first request, res_valid is 0. After reset every destination entry (0 to 63) and every aggregation entry (64 to 79) is all zero, so a request issued before any write resolves to an all-zero mask.
- R2: A request presented with req_valid high in cycle n yields res_valid high in cycle n+2. One result is produced per request, in issue order, and back-to-back requests are accepted every cycle.
- R3: When req_hit is 1 and req_dest_idx is 63 or below, the destination entry is entry req_dest_idx.
- R4: When req_hit is 0, the destination entry depends on req_class: 0 (unknown unicast) reads entry 60, 1 (broadcast or non-IP multicast) reads entry 61, 2 (IPv4 multicast) reads entry 62, and 3 (IPv6 multicast) reads entry 63.
- R5: When req_hit is 1 and req_dest_idx is 64 or above, the destination mask is all zero, so res_mask is all zero, CPU bit included.
- R6: The aggregation entry is entry 64 plus req_aggr_code.
- R7: The source entry is entry 80 plus req_src_port. An ingress port number equal to or above the physical port count gives an all-zero source mask.
- R8: Bit NUM_PHYS of res_mask (the CPU port) equals the CPU bit of the destination entry, whatever the aggregation and source entries hold.
- R9: Every physical bit j of res_mask is the AND of bit j of the destination, aggregation and source entries.
- R10: A write with wr_en high in cycle n replaces the addressed entry for every request presented in cycle n+1 or later. A write to an address at or beyond 80 plus the physical port count changes nothing.
- R11: After reset, source entry 80+p holds every physical port bit except bit p, and its CPU bit is 0.
- R12: res_mask is all zero in every cycle in which res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_hit | input | 1 | MAC-table lookup hit |
| req_dest_idx | input | DIDX_W (7) | Destination entry index from the MAC-table hit |
| req_class | input | 2 | Flood class used on a miss (0 unicast, 1 broadcast/non-IP multicast, 2 IPv4 multicast, 3 IPv6 multicast) |
| req_aggr_code | input | 4 | Link aggregation code |
| req_src_port | input | PORT_W (4) | Ingress port number |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W (7) | Table entry address |
| wr_data | input | MASK_W (12) | Entry mask to store |
| res_valid | output | 1 | Result strobe |
| res_mask | output | MASK_W (12) | Resolved egress mask, bit NUM_PHYS is the CPU port |

## Verification
The assertions check on every cycle:
- the two-cycle request-to-result spacing, and that no result appears without a request;
- that the mask is zero while idle;
- that an out-of-range hit index drops the frame;
- that the result never holds a bit absent from the destination entry read for it;
- that the CPU bit always copies that entry's CPU bit.

Only the bench's sweeps can show the rest: which entry each hit index, flood class, aggregation code and ingress port actually selects; the reset contents of the source entries; that writes become visible to the next request; and that out-of-range writes and ingress ports leave no trace. The bench checks these by comparing every result with a mask computed from its own copy of the table contents.

// File: rtl/pgid_pkg.sv
package pgid_pkg;

   typedef enum logic [1:0] {
      FC_UNICAST = 2'd0,
      FC_BCAST   = 2'd1,
      FC_MC_V4   = 2'd2,
      FC_MC_V6   = 2'd3
   } frame_class_e;

   // Fixed table layout: the positions below are decoded by the lookup paths.
   localparam int DEST_SPAN  = 64;
   localparam int CPU_GROUP  = 59;
   localparam int FLOOD_BASE = 60;
   localparam int AGGR_BASE  = 64;
   localparam int AGGR_SPAN  = 16;
   localparam int AGGR_W     = 4;
   localparam int SRC_BASE   = 80;

   function automatic int flood_entry(frame_class_e cls);
      return FLOOD_BASE + int'(cls);
   endfunction

endpackage

// File: rtl/pgid_index_gen.sv
module pgid_index_gen
   import pgid_pkg::*;
#(
   parameter int NUM_PHYS = 11,
   parameter int DIDX_W   = 7,
   parameter int PORT_W   = 4,
   parameter int ADDR_W   = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_hit,
   input  logic [DIDX_W-1:0]   req_dest_idx,
   input  logic [1:0]          req_class,
   input  logic [AGGR_W-1:0]   req_aggr_code,
   input  logic [PORT_W-1:0]   req_src_port,
   output logic                s1_valid,
   output logic [ADDR_W-1:0]   s1_dest_addr,
   output logic                s1_dest_drop,
   output logic [ADDR_W-1:0]   s1_aggr_addr,
   output logic [ADDR_W-1:0]   s1_src_addr,
   output logic                s1_src_drop
);

   logic              idx_too_big;
   logic [ADDR_W-1:0] dest_addr_d;
   logic [ADDR_W-1:0] src_addr_d;
   logic              src_drop_d;

   // Variant choice: a 6-bit index can never leave the destination range.
   generate
      if (DIDX_W > 6) begin : g_wide_idx
         assign idx_too_big = |req_dest_idx[DIDX_W-1:6];
      end else begin : g_narrow_idx
         assign idx_too_big = 1'b0;
      end
   endgenerate

   always_comb begin
      if (req_hit) begin
         dest_addr_d = ADDR_W'(req_dest_idx[5:0]);
      end else begin
         dest_addr_d = ADDR_W'(flood_entry(frame_class_e'(req_class)));
      end
   end

   assign src_drop_d = (int'(req_src_port) >= NUM_PHYS);
   assign src_addr_d = src_drop_d ? '0 : ADDR_W'(SRC_BASE + int'(req_src_port));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid     <= 1'b0;
         s1_dest_addr <= '0;
         s1_dest_drop <= 1'b0;
         s1_aggr_addr <= '0;
         s1_src_addr  <= '0;
         s1_src_drop  <= 1'b0;
      end else begin
         s1_valid     <= req_valid;
         s1_dest_addr <= dest_addr_d;
         s1_dest_drop <= req_hit & idx_too_big;
         s1_aggr_addr <= ADDR_W'(AGGR_BASE + int'(req_aggr_code));
         s1_src_addr  <= src_addr_d;
         s1_src_drop  <= src_drop_d;
      end
   end

endmodule

// File: rtl/pgid_table.sv
module pgid_table
   import pgid_pkg::*;
#(
   parameter int NUM_PHYS = 11,
   parameter int MASK_W   = 12,
   parameter int DEPTH    = 91,
   parameter int ADDR_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [MASK_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_dest_addr,
   input  logic [ADDR_W-1:0] rd_aggr_addr,
   input  logic [ADDR_W-1:0] rd_src_addr,
   output logic [MASK_W-1:0] rd_dest_data,
   output logic [MASK_W-1:0] rd_aggr_data,
   output logic [MASK_W-1:0] rd_src_data
);

   localparam int SLOTS = 1 << ADDR_W;
   localparam logic [MASK_W-1:0] PHYS_ALL = (MASK_W'(1) << NUM_PHYS) - MASK_W'(1);

   logic [MASK_W-1:0] slot [SLOTS];

   // Real entries are flops; the padding up to a power of two reads as zero
   // and swallows writes, which keeps every read and write index in range.
   generate
      for (genvar e = 0; e < SLOTS; e++) begin : g_slot
         if (e < DEPTH) begin : g_real
            localparam logic [MASK_W-1:0] INIT =
               (e >= SRC_BASE) ? (PHYS_ALL & ~(MASK_W'(1) << (e - SRC_BASE))) : '0;
            logic [MASK_W-1:0] q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  q <= INIT;
               end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
                  q <= wr_data;
               end
            end
            assign slot[e] = q;
         end else begin : g_pad
            assign slot[e] = '0;
         end
      end
   endgenerate

   assign rd_dest_data = slot[rd_dest_addr];
   assign rd_aggr_data = slot[rd_aggr_addr];
   assign rd_src_data  = slot[rd_src_addr];

endmodule

// File: rtl/pgid_combine.sv
module pgid_combine #(
   parameter int NUM_PHYS = 11,
   parameter int MASK_W   = 12
) (
   input  logic [MASK_W-1:0] dest_mask,
   input  logic [MASK_W-1:0] aggr_mask,
   input  logic [MASK_W-1:0] src_mask,
   output logic [MASK_W-1:0] out_mask
);

   localparam int CPU_BIT = NUM_PHYS;

   generate
      for (genvar b = 0; b < MASK_W; b++) begin : g_bit
         if (b == CPU_BIT) begin : g_cpu
            assign out_mask[b] = dest_mask[b];
         end else begin : g_phys
            assign out_mask[b] = dest_mask[b] & aggr_mask[b] & src_mask[b];
         end
      end
   endgenerate

endmodule

// File: rtl/pgid_resolver.sv
module pgid_resolver
   import pgid_pkg::*;
#(
   parameter int  NUM_PHYS = 11,
   parameter int  DIDX_W   = 7,
   localparam int MASK_W   = NUM_PHYS + 1,
   localparam int PORT_W   = $clog2(MASK_W),
   localparam int DEPTH    = SRC_BASE + NUM_PHYS,
   localparam int ADDR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_hit,
   input  logic [DIDX_W-1:0] req_dest_idx,
   input  logic [1:0]        req_class,
   input  logic [3:0]        req_aggr_code,
   input  logic [PORT_W-1:0] req_src_port,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [MASK_W-1:0] wr_data,
   output logic              res_valid,
   output logic [MASK_W-1:0] res_mask
);

   generate
      if (NUM_PHYS < 1 || NUM_PHYS >= CPU_GROUP) begin : g_bad_ports
         $error("NUM_PHYS must leave the reserved destination entries free");
      end
      if (DIDX_W < 6) begin : g_bad_idx
         $error("DIDX_W must cover the destination range");
      end
   endgenerate

   logic              s1_valid;
   logic [ADDR_W-1:0] s1_dest_addr;
   logic              s1_dest_drop;
   logic [ADDR_W-1:0] s1_aggr_addr;
   logic [ADDR_W-1:0] s1_src_addr;
   logic              s1_src_drop;

   logic [MASK_W-1:0] tbl_dest;
   logic [MASK_W-1:0] tbl_aggr;
   logic [MASK_W-1:0] tbl_src;
   logic [MASK_W-1:0] dest_eff;
   logic [MASK_W-1:0] src_eff;
   logic [MASK_W-1:0] comb_mask;

   pgid_index_gen #(
      .NUM_PHYS (NUM_PHYS),
      .DIDX_W   (DIDX_W),
      .PORT_W   (PORT_W),
      .ADDR_W   (ADDR_W)
   ) u_index (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_hit       (req_hit),
      .req_dest_idx  (req_dest_idx),
      .req_class     (req_class),
      .req_aggr_code (req_aggr_code),
      .req_src_port  (req_src_port),
      .s1_valid      (s1_valid),
      .s1_dest_addr  (s1_dest_addr),
      .s1_dest_drop  (s1_dest_drop),
      .s1_aggr_addr  (s1_aggr_addr),
      .s1_src_addr   (s1_src_addr),
      .s1_src_drop   (s1_src_drop)
   );

   pgid_table #(
      .NUM_PHYS (NUM_PHYS),
      .MASK_W   (MASK_W),
      .DEPTH    (DEPTH),
      .ADDR_W   (ADDR_W)
   ) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_dest_addr (s1_dest_addr),
      .rd_aggr_addr (s1_aggr_addr),
      .rd_src_addr  (s1_src_addr),
      .rd_dest_data (tbl_dest),
      .rd_aggr_data (tbl_aggr),
      .rd_src_data  (tbl_src)
   );

   assign dest_eff = s1_dest_drop ? '0 : tbl_dest;
   assign src_eff  = s1_src_drop  ? '0 : tbl_src;

   pgid_combine #(
      .NUM_PHYS (NUM_PHYS),
      .MASK_W   (MASK_W)
   ) u_combine (
      .dest_mask (dest_eff),
      .aggr_mask (tbl_aggr),
      .src_mask  (src_eff),
      .out_mask  (comb_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_mask  <= '0;
      end else begin
         res_valid <= s1_valid;
         res_mask  <= s1_valid ? comb_mask : '0;
      end
   end

endmodule

// File: rtl/pgid_resolver_chk.sv
module pgid_resolver_chk #(
   parameter int NUM_PHYS = 11,
   parameter int DIDX_W   = 7,
   parameter int MASK_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_hit,
   input logic [DIDX_W-1:0] req_dest_idx,
   input logic              res_valid,
   input logic [MASK_W-1:0] res_mask,
   input logic              s1_valid,
   input logic [MASK_W-1:0] dest_mask
);

   // R2: each request yields a result two cycles later
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ##2 res_valid);

   // R2: no result without a request two cycles earlier
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(req_valid, 2));

   // R12: idle output is zero
   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_mask == '0));

   // R5: out-of-range hit index drops the frame
   a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit && (int'(req_dest_idx) >= 64)) |-> ##2 (res_mask == '0));

   // R8: CPU bit follows the destination entry read for this result
   a_r8_cpu_kept: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> (res_mask[NUM_PHYS] == $past(dest_mask[NUM_PHYS])));

   // R9: the result never carries a bit the destination entry lacks
   a_r9_within_dest: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> ((res_mask & ~$past(dest_mask)) == '0));

endmodule

bind pgid_resolver pgid_resolver_chk #(
   .NUM_PHYS (NUM_PHYS),
   .DIDX_W   (DIDX_W),
   .MASK_W   (MASK_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_hit      (req_hit),
   .req_dest_idx (req_dest_idx),
   .res_valid    (res_valid),
   .res_mask     (res_mask),
   .s1_valid     (s1_valid),
   .dest_mask    (dest_eff)
);

// File: tb/sim_pgid_resolver.sv
module sim_pgid_resolver;

   localparam int N = 11;
   localparam logic [11:0] PHYS = 12'h7FF;
   localparam logic [11:0] CPU  = 12'h800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_hit = 1'b0;
   logic [6:0]  req_dest_idx = '0;
   logic [1:0]  req_class = '0;
   logic [3:0]  req_aggr_code = '0;
   logic [3:0]  req_src_port = '0;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic        res_valid;
   logic [11:0] res_mask;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [11:0] dest_model [64];
   logic [11:0] aggr_model [16];
   logic [11:0] src_model  [16];

   logic [11:0] exp_q [4096];
   string       tag_q [4096];
   int          q_head = 0;
   int          q_tail = 0;

   always #2 clk = ~clk;

   pgid_resolver u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_hit       (req_hit),
      .req_dest_idx  (req_dest_idx),
      .req_class     (req_class),
      .req_aggr_code (req_aggr_code),
      .req_src_port  (req_src_port),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .res_valid     (res_valid),
      .res_mask      (res_mask)
   );

   function automatic logic [11:0] dval(int i);
      if (i < N)  return 12'(1) << i;
      if (i == 59) return CPU;
      if (i == 60) return 12'hFFF;
      return 12'((i * 693) ^ (i << 3));
   endfunction

   function automatic logic [11:0] aval(int c);
      return (PHYS & ~(12'(1) << (c % N))) | (((c % 2) == 1) ? CPU : 12'h000);
   endfunction

   function automatic logic [11:0] expect_mask(bit hit, int idx, int cls, int code, int port);
      logic [11:0] d;
      logic [11:0] s;
      logic [11:0] r;
      d = hit ? ((idx > 63) ? 12'h000 : dest_model[idx]) : dest_model[60 + cls];
      s = (port < N) ? src_model[port] : 12'h000;
      r = d & aggr_model[code] & s;
      r[N] = d[N];
      return r;
   endfunction

   task automatic check(bit ok, string tag, logic [11:0] act, logic [11:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(bit hit, int idx, int cls, int code, int port, string tag);
      @(posedge clk); #1;
      req_valid     = 1'b1;
      req_hit       = hit;
      req_dest_idx  = 7'(idx);
      req_class     = 2'(cls);
      req_aggr_code = 4'(code);
      req_src_port  = 4'(port);
      exp_q[q_tail] = expect_mask(hit, idx, cls, code, port);
      tag_q[q_tail] = tag;
      q_tail++;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic tbl_write(int addr, logic [11:0] data);
      @(posedge clk); #1;
      req_valid = 1'b0;
      wr_en   = 1'b1;
      wr_addr = 7'(addr);
      wr_data = data;
      @(posedge clk); #1;
      wr_en = 1'b0;
      if (addr < 64) dest_model[addr] = data;
      else if (addr < 80) aggr_model[addr - 64] = data;
      else if (addr < 80 + N) src_model[addr - 80] = data;
   endtask

   // Result scoreboard: outputs sampled on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (res_valid) begin
            if (q_head == q_tail) begin
               check(1'b0, "R2 result without request", res_mask, 12'h000);
            end else begin
               check(res_mask == exp_q[q_head], tag_q[q_head], res_mask, exp_q[q_head]);
               q_head++;
            end
         end else begin
            check(res_mask == 12'h000, "R12 idle mask", res_mask, 12'h000);
         end
      end
   end

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) dest_model[i] = 12'h000;
      for (int i = 0; i < 16; i++) aggr_model[i] = 12'h000;
      for (int i = 0; i < 16; i++) src_model[i] = (i < N) ? (PHYS & ~(12'(1) << i)) : 12'h000;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(res_valid == 1'b0, "R1 valid in reset", 12'(res_valid), 12'h000);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0, "R1 valid after reset", 12'(res_valid), 12'h000);

      // R1: zeroed destination and aggregation entries resolve to nothing
      issue(1'b1, 3, 0, 2, 0, "R1 zero table hit");
      issue(1'b1, 59, 0, 0, 1, "R1 zero table cpu group");
      for (int c = 0; c < 4; c++) issue(1'b0, 0, c, c, 2, "R1 zero table miss");
      idle();

      for (int i = 0; i < 64; i++) tbl_write(i, dval(i));
      for (int c = 0; c < 16; c++) tbl_write(64 + c, aval(c));

      // R2: a lone request shows up exactly two cycles later
      issue(1'b1, 60, 0, 1, 4, "R2 lone request");
      idle();
      @(negedge clk);
      check(res_valid == 1'b0, "R2 early valid", 12'(res_valid), 12'h000);
      @(negedge clk);
      check(res_valid == 1'b1, "R2 on-time valid", 12'(res_valid), 12'h001);

      // R3 R6 R8 R9 R11: every hit index against every ingress port
      for (int i = 0; i < 64; i++)
         for (int p = 0; p < 16; p++)
            issue(1'b1, i, 0, (i + p) % 16, p, "R3 R6 R7 R8 R9 R11 hit sweep");

      // R4 R6 R7: every flood class, aggregation code and ingress port
      for (int c = 0; c < 4; c++)
         for (int a = 0; a < 16; a++)
            for (int p = 0; p < 16; p++)
               issue(1'b0, 127, c, a, p, "R4 R6 R7 R8 miss sweep");

      // R5: out-of-range hit indices
      for (int i = 64; i < 128; i++) issue(1'b1, i, i % 4, 1, i % N, "R5 clamp");
      idle();

      // R10: a write is seen by the next request
      tbl_write(60, 12'hDA5);
      issue(1'b0, 0, 0, 2, 5, "R10 write visible");
      // R7: overriding a source entry permits self forwarding
      tbl_write(83, PHYS);
      issue(1'b1, 3, 0, 0, 3, "R7 source override");
      // R10: writes past the table are ignored; R7 out-of-range port
      tbl_write(80 + N, 12'hFFF);
      tbl_write(127, 12'hFFF);
      issue(1'b0, 0, 0, 2, N, "R10 R7 ignored write");
      issue(1'b0, 0, 0, 2, 15, "R10 R7 ignored write high");
      idle();

      repeat (4) @(posedge clk);
      @(negedge clk);
      check(q_head == q_tail, "R2 all results delivered", 12'(q_tail - q_head), 12'h000);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule